// File: doc/BRIEF.md
# Configurable pixel component extractor

This block turns raw framebuffer pixel words into one byte each of red, green and blue. For every colour channel it takes a programmed bit field out of the pixel word. It then stretches that field to a full byte by repeating its top bits. A per-channel fallback colour replaces the result when the channel is switched off, when the pixel lies outside the visible area, or when the pixel fetch came up short.

Software programs four configuration words through a simple write port. The first is a pixel-size word, which sets how many bytes of the input word belong to the pixel. The other three are colour-select words, one for each channel. The pixel stream then runs through a single register stage, so results appear one clock after the input.

Top module: `pixel_component_extractor`

## Requirements
- R1: After reset the three colour outputs and out_valid are zero, the pixel size is one byte, and every channel has length zero and fallback zero.
- R2: A write to cfg_addr 0 sets the pixel size from cfg_wdata[4:3], which holds the byte count minus one. Pixel bytes above that size read as zero before any field is taken.
- R3: Writes to cfg_addr 1, 2 and 3 program the red, green and blue channel. In each of these words, bits [4:0] give the pixel bit that becomes the field's least significant bit.
- R4: Bits [11:8] of a channel word give the field length. Bits [23:16] give the channel's fallback byte, which is output whenever the length is zero.
- R5: When pix_visible is low, every channel outputs its fallback byte.
- R6: When pix_underrun is high, every channel outputs its fallback byte.
- R7: A field of 1 to 7 bits is placed at the top of the output byte, and its bits are repeated from the top downward to fill the lower positions (a 5-bit field abcde becomes abcdeabc).
- R8: A field longer than 8 bits yields its 8 most significant bits.
- R9: Colour outputs are registered. out_valid equals pix_valid delayed by exactly one clock.
- R10: While pix_valid is low, the colour outputs keep their last values.
- R11: Field bits at positions beyond the top of the pixel word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select: 0 size, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Configuration write data |
| pix_word | input | WORD_W (32) | Raw pixel word |
| pix_valid | input | 1 | Pixel word is valid this cycle |
| pix_visible | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Pixel fetch underran |
| out_r | output | 8 | Red byte |
| out_g | output | 8 | Green byte |
| out_b | output | 8 | Blue byte |
| out_valid | output | 1 | Output bytes are valid |

## Verification
The bench aims at the field edges, each a place where a plausible design goes wrong.

| Case | What the bench drives | What a faulty design does |
|---|---|---|
| Short fields | 5-bit and 6-bit fields | Zero-fills the low bits instead of repeating the field's top bits, so full-scale inputs never reach 0xFF |
| Pixel size | Data in bytes above the programmed pixel size | Leaks garbage from the unused bytes into a channel |
| Lengths over 8 | A 12-bit field | Keeps the low bits instead of the most significant ones |
| Top of the word | A field that runs past bit 31 | Wraps bits around from the bottom of the word |
| Fallback triggers | Length zero, a hidden pixel and an underrun, each on its own | Ignores one of the three triggers and outputs extracted data |
| Idle cycles | Input changes while pix_valid is low | Lets the colour outputs follow the input instead of holding |

// File: rtl/pixel_component_extractor.sv
module pixel_component_extractor #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [WORD_W-1:0] pix_word,
  input  logic              pix_valid,
  input  logic              pix_visible,
  input  logic              pix_underrun,
  output logic [7:0]        out_r,
  output logic [7:0]        out_g,
  output logic [7:0]        out_b,
  output logic              out_valid
);

  localparam int BYTES = WORD_W / 8;
  localparam int SZ_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int NCH   = 3;

  logic [SZ_W-1:0] size_q;
  logic [4:0]      ofs_q  [NCH];
  logic [3:0]      len_q  [NCH];
  logic [7:0]      dflt_q [NCH];
  logic [7:0]      col_q  [NCH];
  logic [7:0]      col_d  [NCH];
  logic [WORD_W-1:0] masked;

  wire unused_cfg_bits = ^{cfg_wdata[31:24], cfg_wdata[15:12], cfg_wdata[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        ofs_q[c]  <= '0;
        len_q[c]  <= '0;
        dflt_q[c] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == 2'd0) begin
        size_q <= cfg_wdata[3 +: SZ_W];
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (32'(cfg_addr) == c + 1) begin
            ofs_q[c]  <= cfg_wdata[4:0];
            len_q[c]  <= cfg_wdata[11:8];
            dflt_q[c] <= cfg_wdata[23:16];
          end
        end
      end
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign masked[b*8 +: 8] = (32'(b) <= 32'(size_q)) ? pix_word[b*8 +: 8] : 8'h00;
  end

  function automatic logic [7:0] widen(input logic [7:0] t, input logic [3:0] n);
    case (n)
      4'd1:    widen = {8{t[0]}};
      4'd2:    widen = {4{t[1:0]}};
      4'd3:    widen = {t[2:0], t[2:0], t[2:1]};
      4'd4:    widen = {2{t[3:0]}};
      4'd5:    widen = {t[4:0], t[4:2]};
      4'd6:    widen = {t[5:0], t[5:4]};
      4'd7:    widen = {t[6:0], t[6]};
      default: widen = t;
    endcase
  endfunction

  wire use_dflt_all = !pix_visible || pix_underrun;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WORD_W-1:0] shifted;
    logic [3:0]        keep;
    logic [3:0]        drop;
    logic [7:0]        top;

    assign shifted = masked >> ofs_q[c];
    assign keep    = (len_q[c] > 4'd8) ? 4'd8 : len_q[c];
    assign drop    = (len_q[c] > 4'd8) ? len_q[c] - 4'd8 : 4'd0;
    assign top     = 8'(shifted >> drop);
    assign col_d[c] = (use_dflt_all || len_q[c] == 4'd0) ? dflt_q[c] : widen(top, keep);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         col_q[c] <= 8'h00;
      else if (pix_valid) col_q[c] <= col_d[c];
    end

    p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && len_q[c] == 4'd0 && !cfg_we) |=> col_q[c] == $past(dflt_q[c]));
    p_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_visible) |=> col_q[c] == $past(dflt_q[c]));
    p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_underrun) |=> col_q[c] == $past(dflt_q[c]));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(col_q[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;
  end

  assign out_r = col_q[0];
  assign out_g = col_q[1];
  assign out_b = col_q[2];

  p_valid_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  p_valid_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

endmodule

// File: tb/pixel_component_extractor_tb.sv
module pixel_component_extractor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pix_word = '0;
  logic        pix_valid = 1'b0;
  logic        pix_visible = 1'b1;
  logic        pix_underrun = 1'b0;
  logic [7:0]  out_r, out_g, out_b;
  logic        out_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int         m_bm1 = 0;
  int         m_ofs [3] = '{0, 0, 0};
  int         m_len [3] = '{0, 0, 0};
  logic [7:0] m_dflt [3] = '{8'h00, 8'h00, 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_component_extractor u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_word(pix_word), .pix_valid(pix_valid),
    .pix_visible(pix_visible), .pix_underrun(pix_underrun),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [31:0] w, input int ch, input bit vis, input bit und);
    logic [31:0] m;
    logic [63:0] f;
    logic [7:0]  o;
    int n;
    m = w;
    for (int b = 0; b < 4; b++) if (b > m_bm1) m[b*8 +: 8] = 8'h00;
    if (m_len[ch] == 0 || !vis || und) return m_dflt[ch];
    f = ({32'h0, m} >> m_ofs[ch]) & ((64'd1 << m_len[ch]) - 64'd1);
    if (m_len[ch] > 8) begin
      f = f >> (m_len[ch] - 8);
      n = 8;
    end else n = m_len[ch];
    for (int i = 0; i < 8; i++) o[7-i] = f[n - 1 - (i % n)];
    return o;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_size(input int bm1);
    m_bm1 = bm1;
    cfg_write(2'd0, 32'(bm1) << 3);
  endtask

  task automatic set_chan(input int ch, input int ofs, input int len, input logic [7:0] dv);
    m_ofs[ch] = ofs; m_len[ch] = len; m_dflt[ch] = dv;
    cfg_write(2'(ch + 1), {8'h00, dv, 4'h0, 4'(len), 3'h0, 5'(ofs)});
  endtask

  task automatic push(input string req, input logic [31:0] w, input bit vis, input bit und);
    @(negedge clk);
    pix_word = w; pix_visible = vis; pix_underrun = und; pix_valid = 1'b1;
    chk({req, " valid low before edge"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    pix_valid = 1'b0;
    chk({req, " R9 valid one cycle later"}, 32'(out_valid), 32'd1);
    chk({req, " red"},   32'(out_r), 32'(model(w, 0, vis, und)));
    chk({req, " green"}, 32'(out_g), 32'(model(w, 1, vis, und)));
    chk({req, " blue"},  32'(out_b), 32'(model(w, 2, vis, und)));
    @(negedge clk);
    chk({req, " R9 valid drops"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset red", 32'(out_r), 0);
    chk("R1 reset green", 32'(out_g), 0);
    chk("R1 reset blue", 32'(out_b), 0);
    chk("R1 reset valid", 32'(out_valid), 0);
    push("R1 unprogrammed", 32'hFFFF_FFFF, 1, 0);
  endtask

  task automatic t_rgb565;
    set_size(1);
    set_chan(0, 11, 5, 8'h11);
    set_chan(1, 5, 6, 8'h22);
    set_chan(2, 0, 5, 8'h33);
    push("R7 R3 565 red full", 32'h0000_F800, 1, 0);
    chk("R7 red full scale", 32'(out_r), 32'hFF);
    push("R7 R3 565 green full", 32'h0000_07E0, 1, 0);
    chk("R7 green full scale", 32'(out_g), 32'hFF);
    push("R7 565 mixed", 32'h0000_8A51, 1, 0);
    chk("R7 red 10001 widened", 32'(out_r), 32'h8C);
  endtask

  task automatic t_size;
    set_size(0);
    set_chan(0, 8, 8, 8'h00);
    push("R2 byte above size", 32'h0000_AB12, 1, 0);
    chk("R2 masked byte reads zero", 32'(out_r), 32'h00);
    set_size(1);
    push("R2 byte within size", 32'h0000_AB12, 1, 0);
    chk("R2 byte passes", 32'(out_r), 32'hAB);
  endtask

  task automatic t_rgb888;
    set_size(3);
    set_chan(0, 16, 8, 8'h00);
    set_chan(1, 8, 8, 8'h00);
    set_chan(2, 0, 8, 8'h00);
    push("R3 888 a", 32'h00C3_5A96, 1, 0);
    push("R3 888 b", 32'hFF01_80FE, 1, 0);
  endtask

  task automatic t_clamp;
    set_chan(0, 4, 12, 8'h00);
    push("R8 twelve bit field", 32'h0000_ABC0, 1, 0);
    chk("R8 top eight bits", 32'(out_r), 32'hAB);
  endtask

  task automatic t_top_edge;
    set_chan(1, 28, 8, 8'h00);
    push("R11 past word top", 32'hF000_0000, 1, 0);
    chk("R11 upper bits zero", 32'(out_g), 32'h0F);
  endtask

  task automatic t_defaults;
    set_chan(0, 0, 0, 8'h5A);
    set_chan(1, 0, 8, 8'hA5);
    set_chan(2, 8, 4, 8'h3C);
    push("R4 zero length", 32'h1234_5678, 1, 0);
    chk("R4 red fallback", 32'(out_r), 32'h5A);
    push("R5 hidden pixel", 32'h1234_5678, 0, 0);
    chk("R5 green fallback", 32'(out_g), 32'hA5);
    push("R6 underrun", 32'h1234_5678, 1, 1);
    chk("R6 blue fallback", 32'(out_b), 32'h3C);
  endtask

  task automatic t_hold;
    logic [7:0] r0, g0, b0;
    push("R10 prime", 32'h00FF_EE0D, 1, 0);
    r0 = out_r; g0 = out_g; b0 = out_b;
    @(negedge clk);
    pix_word = 32'h0102_0304; pix_visible = 1'b0; pix_underrun = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 red held", 32'(out_r), 32'(r0));
    chk("R10 green held", 32'(out_g), 32'(g0));
    chk("R10 blue held", 32'(out_b), 32'(b0));
    chk("R10 valid stays low", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rgb565();
    t_size();
    t_rgb888();
    t_clamp();
    t_top_edge();
    t_defaults();
    t_hold();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule